// File: doc/BRIEF.md
# Configuration Identity Loader

This block supplies the read-only identity fields of a PCI-style configuration header. The values come from a small external configuration memory rather than being fixed. After reset it fetches four 16-bit words through a simple word-read port. It issues one request at a time and waits for each response strobe. A control field in the first word decides whether the stored values or the built-in defaults become the identity.

A byte-wide configuration read port returns the identity bytes in little-endian order. It also returns a fixed capabilities pointer. Until loading has finished, the identity bytes read as all ones. A `ready` output shows when the values are final. If the memory stops answering, the block falls back to the defaults after a bounded wait. Configuration writes are accepted on the port and discarded.

Top module: `cfg_ident_loader`

## Requirements
- R1: After reset the block issues exactly four word reads, at memory addresses 0Ah, 0Bh, 0Ch and 23h in that order. `ee_req` is a one-cycle pulse, and the next request comes only after `ee_rvalid` has returned the previous word.
- R2: `ready` is 0 until the fourth word has been received or a timeout has occurred. While `ready` is 0, every identity byte (offsets 00h–03h, 08h and 2Ch–2Fh) reads FFh.
- R3: When bits 15:14 of word 0Ah are 00b, 10b or 11b, the identity is: device 1051h, vendor 8086h, revision 00h, subsystem 0000h and subsystem vendor 0000h. The other words and bits are ignored.
- R4: When bits 15:14 of word 0Ah are 01b and bit 13 is 0, the subsystem ID equals word 0Bh and the subsystem vendor ID equals word 0Ch. The vendor ID stays 8086h and the revision stays 00h.
- R5: When bits 15:14 of word 0Ah are 01b and bit 13 is 1, the vendor ID equals word 0Ch. The revision equals 80h plus bits 10:8 of word 0Ah.
- R6: When bits 15:14 of word 0Ah are 01b, the device ID equals word 23h, except when that word is 0000h or FFFFh; in that case the device ID stays 1051h.
- R7: Byte layout is little-endian:
  - vendor ID at 00h (low) and 01h;
  - device ID at 02h and 03h;
  - revision at 08h;
  - subsystem vendor ID at 2Ch and 2Dh;
  - subsystem ID at 2Eh and 2Fh.
  
  Every other offset except 34h reads 00h.
- R8: Offset 34h always reads DCh, including before `ready`.
- R9: If a response does not arrive within 1024 cycles of entering the wait, the block stops fetching, keeps the R3 defaults for every field and raises `ready`.
- R10: Configuration writes (`cfg_wr_en`) change no readable byte.
- R11: A read with `cfg_rd_en` high at a clock edge returns `cfg_rdata` with `cfg_rvalid` high after that edge, for one cycle.
- R12: Once `ready` is high it stays high until reset, and no further memory requests are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ee_req | output | 1 | One-cycle word read request |
| ee_addr | output | 8 | Word address of the request |
| ee_rvalid | input | 1 | Response strobe |
| ee_rdata | input | 16 | Response word |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_wr_en | input | 1 | Configuration write strobe (ignored) |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data (ignored) |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 8 | Read data byte |
| ready | output | 1 | Identity values are final |

## Verification
The embedded assertions watch the protocol-level properties on every cycle:
- the request pulse is a single cycle;
- the wait counter stays bounded;
- the fetched image is frozen once loading ends;
- `ready` never falls and no request follows it;
- writes never disturb the identity;
- the capabilities byte and the all-ones pre-ready bytes are returned.

The value choices cannot be seen by a per-cycle property; only the directed scenarios show them. These include the mode and extension decoding, the computed revision, the rejection of 0000h/FFFFh device words, the request order, and the exact timeout fallback.

// File: rtl/idl_pkg.sv
package idl_pkg;

    localparam int N_WORDS = 4;
    localparam int IW      = $clog2(N_WORDS);

    localparam logic [15:0] DEF_DEV     = 16'h1051;
    localparam logic [15:0] DEF_VEN     = 16'h8086;
    localparam logic [7:0]  DEF_REV     = 8'h00;
    localparam logic [7:0]  REV_EE_BASE = 8'h80;
    localparam logic [7:0]  CAP_PTR_VAL = 8'hDC;
    localparam logic [1:0]  MODE_EE     = 2'b01;

    // identity register set
    typedef struct packed {
        logic [15:0] dev_id;
        logic [15:0] ven_id;
        logic [7:0]  rev_id;
        logic [15:0] sub_id;
        logic [15:0] sub_ven;
    } ident_t;

    localparam ident_t IDENT_DEFAULT = '{
        dev_id:  DEF_DEV,
        ven_id:  DEF_VEN,
        rev_id:  DEF_REV,
        sub_id:  16'h0000,
        sub_ven: 16'h0000
    };

    // fields extracted from the fetched words
    typedef struct packed {
        logic        sel_ee;
        logic        ext_id;
        logic [2:0]  rev_lo;
        logic [15:0] sub_id;
        logic [15:0] sub_ven;
        logic [15:0] dev_word;
    } ee_img_t;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_ISSUE,
        LD_WAIT,
        LD_DONE
    } ld_state_e;

    // memory word address for each fetch slot; the order is the fetch order
    function automatic logic [7:0] slot_addr(input logic [IW-1:0] slot);
        case (slot)
            2'd0:    slot_addr = 8'h0A;
            2'd1:    slot_addr = 8'h0B;
            2'd2:    slot_addr = 8'h0C;
            default: slot_addr = 8'h23;
        endcase
    endfunction

endpackage

// File: rtl/idl_word_fetch.sv
module idl_word_fetch
    import idl_pkg::*;
#(
    parameter int TIMEOUT = 1024,
    parameter int EE_AW   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ee_req,
    output logic [EE_AW-1:0] ee_addr,
    input  logic             ee_rvalid,
    input  logic [15:0]      ee_rdata,
    output ee_img_t          img,
    output logic             fetch_done,
    output logic             fetch_ok
);

    localparam int TW = $clog2(TIMEOUT + 1);

    typedef struct packed {
        ld_state_e   st;
        logic [IW-1:0] idx;
        logic [TW-1:0] timer;
        ee_img_t     img;
        logic        ok;
    } fetch_st_t;

    fetch_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            LD_IDLE: s_d.st = LD_ISSUE;

            LD_ISSUE: begin
                s_d.st    = LD_WAIT;
                s_d.timer = '0;
            end

            LD_WAIT: begin
                if (ee_rvalid) begin
                    case (s_q.idx)
                        2'd0: begin
                            s_d.img.sel_ee = (ee_rdata[15:14] == MODE_EE);
                            s_d.img.ext_id = ee_rdata[13];
                            s_d.img.rev_lo = ee_rdata[10:8];
                        end
                        2'd1:    s_d.img.sub_id   = ee_rdata;
                        2'd2:    s_d.img.sub_ven  = ee_rdata;
                        default: s_d.img.dev_word = ee_rdata;
                    endcase
                    if (s_q.idx == IW'(N_WORDS - 1)) begin
                        s_d.st = LD_DONE;
                        s_d.ok = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.st  = LD_ISSUE;
                    end
                end else if (s_q.timer == TW'(TIMEOUT - 1)) begin
                    s_d.st = LD_DONE;
                    s_d.ok = 1'b0;
                end else begin
                    s_d.timer = s_q.timer + 1'b1;
                end
            end

            default: s_d.st = LD_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: LD_IDLE, idx: '0, timer: '0, img: '0, ok: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ee_req     = (s_q.st == LD_ISSUE);
    assign ee_addr    = EE_AW'(slot_addr(s_q.idx));
    assign img        = s_q.img;
    assign fetch_done = (s_q.st == LD_DONE);
    assign fetch_ok   = s_q.ok;

    // R1
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req |=> !ee_req);

    // R9
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == LD_WAIT) |-> (s_q.timer < TW'(TIMEOUT)));

    // R12
    image_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> (fetch_done && $stable(img) && $stable(fetch_ok)));

endmodule

// File: rtl/idl_ident_decode.sv
module idl_ident_decode
    import idl_pkg::*;
(
    input  ee_img_t img,
    input  logic    use_img,
    output ident_t  ident
);

    logic dev_word_ok;

    always_comb begin
        dev_word_ok = (img.dev_word != 16'h0000) && (img.dev_word != 16'hFFFF);
        ident       = IDENT_DEFAULT;
        if (use_img && img.sel_ee) begin
            ident.sub_id  = img.sub_id;
            ident.sub_ven = img.sub_ven;
            if (dev_word_ok) begin
                ident.dev_id = img.dev_word;
            end
            if (img.ext_id) begin
                ident.ven_id = img.sub_ven;
                ident.rev_id = REV_EE_BASE + {5'b0, img.rev_lo};
            end
        end
    end

endmodule

// File: rtl/idl_cfg_readport.sv
module idl_cfg_readport
    import idl_pkg::*;
#(
    parameter int CA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ident_t          ident,
    input  logic            ident_ok,
    input  logic            rd_en,
    input  logic [CA_W-1:0] rd_addr,
    output logic            rvalid,
    output logic [7:0]      rdata
);

    typedef struct packed {
        logic       vld;
        logic [7:0] data;
    } rp_st_t;

    rp_st_t r_d, r_q;
    logic [7:0] byte_v;
    logic       is_ident;

    always_comb begin
        is_ident = 1'b1;
        case (rd_addr)
            CA_W'(8'h00): byte_v = ident.ven_id[7:0];
            CA_W'(8'h01): byte_v = ident.ven_id[15:8];
            CA_W'(8'h02): byte_v = ident.dev_id[7:0];
            CA_W'(8'h03): byte_v = ident.dev_id[15:8];
            CA_W'(8'h08): byte_v = ident.rev_id;
            CA_W'(8'h2C): byte_v = ident.sub_ven[7:0];
            CA_W'(8'h2D): byte_v = ident.sub_ven[15:8];
            CA_W'(8'h2E): byte_v = ident.sub_id[7:0];
            CA_W'(8'h2F): byte_v = ident.sub_id[15:8];
            CA_W'(8'h34): begin
                byte_v   = CAP_PTR_VAL;
                is_ident = 1'b0;
            end
            default: begin
                byte_v   = 8'h00;
                is_ident = 1'b0;
            end
        endcase

        r_d     = r_q;
        r_d.vld = rd_en;
        if (rd_en) begin
            r_d.data = (is_ident && !ident_ok) ? 8'hFF : byte_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{vld: 1'b0, data: 8'h00};
        end else begin
            r_q <= r_d;
        end
    end

    assign rvalid = r_q.vld;
    assign rdata  = r_q.data;

    // R8
    cap_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && $past(rd_addr) == CA_W'(8'h34)) |-> (rdata == CAP_PTR_VAL));

    // R2
    pre_ready_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !$past(ident_ok) && $past(rd_addr) == CA_W'(8'h02)) |-> (rdata == 8'hFF));

    // R11
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

endmodule

// File: rtl/cfg_ident_loader.sv
module cfg_ident_loader
    import idl_pkg::*;
#(
    parameter int TIMEOUT = 1024,
    parameter int EE_AW   = 8,
    parameter int CA_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ee_req,
    output logic [EE_AW-1:0] ee_addr,
    input  logic             ee_rvalid,
    input  logic [15:0]      ee_rdata,
    input  logic             cfg_rd_en,
    input  logic             cfg_wr_en,
    input  logic [CA_W-1:0]  cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic             cfg_rvalid,
    output logic [7:0]       cfg_rdata,
    output logic             ready
);

    typedef struct packed {
        ident_t id;
        logic   rdy;
    } top_st_t;

    top_st_t t_d, t_q;
    ee_img_t img;
    ident_t  decoded;
    logic    fetch_done;
    logic    fetch_ok;

    idl_word_fetch #(
        .TIMEOUT (TIMEOUT),
        .EE_AW   (EE_AW)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ee_req     (ee_req),
        .ee_addr    (ee_addr),
        .ee_rvalid  (ee_rvalid),
        .ee_rdata   (ee_rdata),
        .img        (img),
        .fetch_done (fetch_done),
        .fetch_ok   (fetch_ok)
    );

    idl_ident_decode u_decode (
        .img     (img),
        .use_img (fetch_ok),
        .ident   (decoded)
    );

    always_comb begin
        t_d = t_q;
        if (!t_q.rdy && fetch_done) begin
            t_d.id  = decoded;
            t_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{id: IDENT_DEFAULT, rdy: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    idl_cfg_readport #(
        .CA_W (CA_W)
    ) u_readport (
        .clk      (clk),
        .rst_n    (rst_n),
        .ident    (t_q.id),
        .ident_ok (t_q.rdy),
        .rd_en    (cfg_rd_en),
        .rd_addr  (cfg_addr),
        .rvalid   (cfg_rvalid),
        .rdata    (cfg_rdata)
    );

    assign ready = t_q.rdy;

    // R12
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R12
    no_req_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !ee_req);

    // R2
    ready_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(fetch_done));

    // R10
    write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && ready && (cfg_wdata != 8'h00)) |=> $stable(t_q.id));

endmodule

// File: tb/tb_cfg_ident_loader.sv
module tb_cfg_ident_loader;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ee_req;
    logic [7:0]  ee_addr;
    logic        ee_rvalid;
    logic [15:0] ee_rdata;
    logic        cfg_rd_en;
    logic        cfg_wr_en;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        cfg_rvalid;
    logic [7:0]  cfg_rdata;
    logic        ready;

    int total = 0;
    int bad   = 0;

    logic [15:0] m0a, m0b, m0c, m23;
    int          lat;
    bit          mute;
    logic [7:0]  req_log [8];
    int          req_cnt;

    always #10 clk = ~clk;

    cfg_ident_loader dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ee_req     (ee_req),
        .ee_addr    (ee_addr),
        .ee_rvalid  (ee_rvalid),
        .ee_rdata   (ee_rdata),
        .cfg_rd_en  (cfg_rd_en),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rvalid (cfg_rvalid),
        .cfg_rdata  (cfg_rdata),
        .ready      (ready)
    );

    function automatic logic [15:0] mem_word(input logic [7:0] a);
        case (a)
            8'h0A:   mem_word = m0a;
            8'h0B:   mem_word = m0b;
            8'h0C:   mem_word = m0c;
            8'h23:   mem_word = m23;
            default: mem_word = 16'hDEAD;
        endcase
    endfunction

    // behavioural word memory
    initial begin
        logic [7:0] a;
        ee_rvalid = 1'b0;
        ee_rdata  = 16'h0000;
        @(negedge clk);
        forever begin
            if (rst_n === 1'b1 && ee_req === 1'b1) begin
                a = ee_addr;
                if (req_cnt < 8) req_log[req_cnt] = a;
                req_cnt++;
                if (!mute) begin
                    repeat (lat) @(negedge clk);
                    ee_rvalid = 1'b1;
                    ee_rdata  = mem_word(a);
                    @(negedge clk);
                    ee_rvalid = 1'b0;
                    ee_rdata  = 16'h0000;
                end else begin
                    @(negedge clk);
                end
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start(input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic [15:0] d,
                         input int l, input bit m);
        @(negedge clk);
        rst_n = 1'b0;
        m0a = a; m0b = b; m0c = c; m23 = d;
        lat = l; mute = m;
        req_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_rd_en = 1'b1;
        cfg_addr  = a;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        d = cfg_rdata;
        chk($sformatf("R11 rvalid for %0h", a), int'(cfg_rvalid), 1);
    endtask

    task automatic expect_byte(input string tag, input logic [7:0] a, input logic [7:0] e);
        logic [7:0] d;
        cfg_read(a, d);
        chk($sformatf("%s offset %0h", tag, a), int'(d), int'(e));
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 4000 && ready !== 1'b1; i++) @(negedge clk);
        chk("R2 ready after load", int'(ready), 1);
    endtask

    task automatic check_order();
        chk("R1 request count", req_cnt, 4);
        chk("R1 first addr", int'(req_log[0]), 8'h0A);
        chk("R1 second addr", int'(req_log[1]), 8'h0B);
        chk("R1 third addr", int'(req_log[2]), 8'h0C);
        chk("R1 fourth addr", int'(req_log[3]), 8'h23);
    endtask

    task automatic check_ident(input string tag, input logic [15:0] dev,
                               input logic [15:0] ven, input logic [7:0] rev,
                               input logic [15:0] sid, input logic [15:0] sven);
        expect_byte({tag, " R7 ven lo"}, 8'h00, ven[7:0]);
        expect_byte({tag, " R7 ven hi"}, 8'h01, ven[15:8]);
        expect_byte({tag, " R7 dev lo"}, 8'h02, dev[7:0]);
        expect_byte({tag, " R7 dev hi"}, 8'h03, dev[15:8]);
        expect_byte({tag, " R7 rev"},    8'h08, rev);
        expect_byte({tag, " R7 sven lo"}, 8'h2C, sven[7:0]);
        expect_byte({tag, " R7 sven hi"}, 8'h2D, sven[15:8]);
        expect_byte({tag, " R7 sid lo"}, 8'h2E, sid[7:0]);
        expect_byte({tag, " R7 sid hi"}, 8'h2F, sid[15:8]);
    endtask

    task automatic t_pre_ready();
        logic [7:0] d;
        start(16'h4700, 16'h1111, 16'h2222, 16'h3333, 40, 1'b0);
        repeat (2) @(negedge clk);
        chk("R2 ready low during load", int'(ready), 0);
        expect_byte("R2 pre-ready", 8'h00, 8'hFF);
        expect_byte("R2 pre-ready", 8'h03, 8'hFF);
        expect_byte("R2 pre-ready", 8'h08, 8'hFF);
        expect_byte("R2 pre-ready", 8'h2F, 8'hFF);
        expect_byte("R8 cap pre-ready", 8'h34, 8'hDC);
        expect_byte("R7 other pre-ready", 8'h05, 8'h00);
        cfg_read(8'h34, d);
        @(negedge clk);
        chk("R11 rvalid one cycle", int'(cfg_rvalid), 0);
        wait_ready();
        check_order();
        check_ident("R4 slow", 16'h3333, 16'h8086, 8'h00, 16'h1111, 16'h2222);
    endtask

    task automatic t_default_modes();
        start(16'hC000, 16'hAAAA, 16'hBBBB, 16'h4321, 1, 1'b0);
        wait_ready();
        check_order();
        check_ident("R3 mode11", 16'h1051, 16'h8086, 8'h00, 16'h0000, 16'h0000);
        start(16'hA700, 16'hAAAA, 16'hBBBB, 16'h4321, 2, 1'b0);
        wait_ready();
        check_ident("R3 mode10", 16'h1051, 16'h8086, 8'h00, 16'h0000, 16'h0000);
        start(16'h2500, 16'hAAAA, 16'hBBBB, 16'h4321, 3, 1'b0);
        wait_ready();
        check_ident("R3 mode00", 16'h1051, 16'h8086, 8'h00, 16'h0000, 16'h0000);
    endtask

    task automatic t_mode_plain();
        start(16'h4200, 16'hABCD, 16'h1357, 16'h2468, 1, 1'b0);
        wait_ready();
        check_order();
        check_ident("R4 plain", 16'h2468, 16'h8086, 8'h00, 16'hABCD, 16'h1357);
    endtask

    task automatic t_mode_ext();
        start(16'h6500, 16'h0F0F, 16'h5A5A, 16'hBEEF, 1, 1'b0);
        wait_ready();
        check_ident("R5 ext rev5", 16'hBEEF, 16'h5A5A, 8'h85, 16'h0F0F, 16'h5A5A);
        start(16'h6700, 16'h0102, 16'hC0DE, 16'h7777, 2, 1'b0);
        wait_ready();
        check_ident("R5 ext rev7", 16'h7777, 16'hC0DE, 8'h87, 16'h0102, 16'hC0DE);
        start(16'h60FF, 16'h0102, 16'hC0DE, 16'h7777, 1, 1'b0);
        wait_ready();
        expect_byte("R5 ext rev0", 8'h08, 8'h80);
    endtask

    task automatic t_devid_invalid();
        start(16'h6300, 16'h1234, 16'h5678, 16'h0000, 1, 1'b0);
        wait_ready();
        check_ident("R6 dev 0000", 16'h1051, 16'h5678, 8'h83, 16'h1234, 16'h5678);
        start(16'h4000, 16'h1234, 16'h5678, 16'hFFFF, 1, 1'b0);
        wait_ready();
        expect_byte("R6 dev FFFF lo", 8'h02, 8'h51);
        expect_byte("R6 dev FFFF hi", 8'h03, 8'h10);
        start(16'h4000, 16'h1234, 16'h5678, 16'h0001, 1, 1'b0);
        wait_ready();
        expect_byte("R6 dev 0001 lo", 8'h02, 8'h01);
        expect_byte("R6 dev 0001 hi", 8'h03, 8'h00);
    endtask

    task automatic t_timeout();
        start(16'h6500, 16'h0F0F, 16'h5A5A, 16'hBEEF, 1, 1'b1);
        repeat (1000) @(negedge clk);
        chk("R9 not ready before timeout", int'(ready), 0);
        repeat (40) @(negedge clk);
        chk("R9 ready after timeout", int'(ready), 1);
        chk("R9 single request", req_cnt, 1);
        check_ident("R9 defaults", 16'h1051, 16'h8086, 8'h00, 16'h0000, 16'h0000);
        expect_byte("R8 cap after timeout", 8'h34, 8'hDC);
    endtask

    task automatic t_writes();
        start(16'h6200, 16'h9ABC, 16'hDEF0, 16'h1357, 1, 1'b0);
        wait_ready();
        foreach (req_log[i]) begin end
        cfg_write(8'h00, 8'h55);
        cfg_write(8'h01, 8'h55);
        cfg_write(8'h02, 8'h55);
        cfg_write(8'h03, 8'h55);
        cfg_write(8'h08, 8'h55);
        cfg_write(8'h2C, 8'h55);
        cfg_write(8'h2D, 8'h55);
        cfg_write(8'h2E, 8'h55);
        cfg_write(8'h2F, 8'h55);
        cfg_write(8'h34, 8'h55);
        cfg_write(8'h04, 8'h55);
        check_ident("R10 after writes", 16'h1357, 16'hDEF0, 8'h82, 16'h9ABC, 16'hDEF0);
        expect_byte("R10 cap after write", 8'h34, 8'hDC);
        expect_byte("R10 R7 unmapped after write", 8'h04, 8'h00);
        expect_byte("R7 unmapped 0F", 8'h0F, 8'h00);
        expect_byte("R7 unmapped 40", 8'h40, 8'h00);
    endtask

    task automatic t_sticky();
        start(16'h4000, 16'h1111, 16'h2222, 16'h3333, 1, 1'b0);
        wait_ready();
        repeat (64) @(negedge clk);
        chk("R12 ready stays high", int'(ready), 1);
        chk("R12 no extra requests", req_cnt, 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        cfg_rd_en = 1'b0;
        cfg_wr_en = 1'b0;
        cfg_addr  = 8'h00;
        cfg_wdata = 8'h00;
        m0a = 16'h0; m0b = 16'h0; m0c = 16'h0; m23 = 16'h0;
        lat = 1; mute = 1'b0; req_cnt = 0;
        repeat (3) @(negedge clk);
        chk("R2 reset ready low", int'(ready), 0);
        chk("R11 reset rvalid low", int'(cfg_rvalid), 0);
        t_pre_ready();
        t_default_modes();
        t_mode_plain();
        t_mode_ext();
        t_devid_invalid();
        t_timeout();
        t_writes();
        t_sticky();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule